// File: doc/BRIEF.md
# Letterbox Black Line Detector

The detector watches the luma samples of every active video line. It decides per line whether the line is black. Per field, it measures two runs: the black lines from the first active line downward, and the black lines that end at the last active line. Those two runs are the top and bottom letterbox bars. It also notes whether every line of the field was black.

Field results are merged into a stored pair of counts by taking the smaller value. Over many fields the stored pair therefore settles on the thinnest bars seen. Software reads the single 16-bit result word. The read returns the current value, and it also restarts the measurement by loading both stored counts with 127.

The pixel stream is marked by three signals:
- `act_vld` marks an active pixel.
- `eol` closes a line.
- `eof` closes a field.

`eof` must arrive at least one cycle after the last `eol` of the field.

A run tracker state machine follows each field through three states:
- `TRK_IDLE`: no line has been seen yet in this field.
- `TRK_TOP`: every line so far has been black.
- `TRK_BODY`: a bright line has been seen.

Its transitions are:
- IDLE→TOP on a black line.
- IDLE→BODY on a bright line.
- TOP→BODY on the first bright line.
- TOP→IDLE and BODY→IDLE on field end, which publishes the field result.
- IDLE→IDLE on field end with no lines, which publishes nothing.

Top module: `lbx_detect`

## Requirements
- R1: After reset the result word reads 16'h7F7F: both counts 127, black-picture flag 0.
- R2: A line is black when no sample with `act_vld` high during that line has luma above 32. A sample presented in the same cycle as `eol` belongs to the closing line. Luma seen while `act_vld` is low is ignored.
- R3: The top count of a field is the number of consecutive black lines starting at the field's first line, saturating at 127 (never wrapping).
- R4: The bottom count of a field is the number of consecutive black lines ending at the field's last line, saturating at 127.
- R5: Two clock edges after the edge that samples `eof`, each stored count becomes the minimum of itself and the new field's count. A stored count never rises except through a read.
- R6: Bit 15 becomes 1 when every line of the latest completed field was black, and 0 otherwise. Only a field result changes it; a read does not.
- R7: An `eof` for a field that had no lines leaves the result word unchanged.
- R8: A read is `acc_stb` high with `acc_wr` low. It sees the current word, and from the next cycle both counts read 127. If a field result lands at the same edge as the read, the counts take that field's values instead.
- R9: An access with `acc_stb` and `acc_wr` both high changes nothing.
- R10: Word layout: bits 6:0 are the bottom count, bit 7 is always 0, bits 14:8 are the top count, and bit 15 is the black-picture flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_vld | input | 1 | Active pixel present this cycle |
| luma | input | 8 | Pixel luma |
| eol | input | 1 | End of active line strobe |
| eof | input | 1 | End of field strobe |
| acc_stb | input | 1 | Register access strobe |
| acc_wr | input | 1 | Access is a write (ignored) |
| rd_data | output | 16 | Result word |

## Verification
The bound assertions check several properties on every cycle:
- A read restores both counts to 127, and a write leaves the word stable.
- The counts never grow without a read, and a landing field can only lower them.
- The flag holds between field results.
- An all-black field result carries equal top and bottom runs.

Only the bench scenarios can show the rest. That covers the exact run lengths, the threshold edge at 32 and 33, and a bright sample arriving with `eol`. It also covers saturation on a 130-line black field, a field with no lines, and a read that coincides with a landing result.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

    localparam int LBX_CNT_W = 7;
    localparam logic [LBX_CNT_W-1:0] LBX_CNT_MAX = '1;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_TOP  = 2'd1,
        TRK_BODY = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic                 all_black;
        logic [LBX_CNT_W-1:0] top;
        logic [LBX_CNT_W-1:0] bot;
    } fld_res_t;

endpackage

// File: rtl/lbx_line_class.sv
module lbx_line_class #(
    parameter int LUMA_W    = 8,
    parameter int BLACK_MAX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_vld,
    input  logic [LUMA_W-1:0] luma,
    input  logic              eol,
    input  logic              eof,
    output logic              line_vld,
    output logic              line_black,
    output logic              fld_end
);

    localparam logic [LUMA_W-1:0] THR = LUMA_W'(BLACK_MAX);

    logic seen_bright;
    logic pix_hot;

    // one active sample above the black level makes the line bright
    always_comb begin
        pix_hot = act_vld && (luma > THR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_bright <= 1'b0;
            line_vld    <= 1'b0;
            line_black  <= 1'b0;
            fld_end     <= 1'b0;
        end else begin
            fld_end <= eof;
            if (eol) begin
                line_vld    <= 1'b1;
                line_black  <= !(seen_bright || pix_hot);
                seen_bright <= 1'b0;
            end else begin
                line_vld    <= 1'b0;
                seen_bright <= seen_bright || pix_hot;
            end
        end
    end

endmodule

// File: rtl/lbx_run_fsm.sv
module lbx_run_fsm
    import lbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_vld,
    input  logic     line_black,
    input  logic     fld_end,
    output logic     fld_vld,
    output fld_res_t fld_res
);

    trk_state_e state_q, state_d;
    logic [LBX_CNT_W-1:0] top_q, bot_q;

    function automatic logic [LBX_CNT_W-1:0] sat_inc(input logic [LBX_CNT_W-1:0] v);
        return (v == LBX_CNT_MAX) ? v : v + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (fld_end) begin
                    state_d = TRK_IDLE;
                end else if (line_vld) begin
                    state_d = line_black ? TRK_TOP : TRK_BODY;
                end
            end
            TRK_TOP: begin
                if (fld_end) begin
                    state_d = TRK_IDLE;
                end else if (line_vld && !line_black) begin
                    state_d = TRK_BODY;
                end
            end
            TRK_BODY: begin
                if (fld_end) begin
                    state_d = TRK_IDLE;
                end
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    // run counters and field result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q   <= '0;
            bot_q   <= '0;
            fld_vld <= 1'b0;
            fld_res <= '0;
        end else begin
            fld_vld <= 1'b0;
            if (fld_end) begin
                if (state_q != TRK_IDLE) begin
                    fld_vld           <= 1'b1;
                    fld_res.all_black <= (state_q == TRK_TOP);
                    fld_res.top       <= top_q;
                    fld_res.bot       <= bot_q;
                end
                top_q <= '0;
                bot_q <= '0;
            end else if (line_vld) begin
                unique case (state_q)
                    TRK_IDLE: begin
                        top_q <= line_black ? LBX_CNT_W'(1) : '0;
                        bot_q <= line_black ? LBX_CNT_W'(1) : '0;
                    end
                    TRK_TOP: begin
                        if (line_black) begin
                            top_q <= sat_inc(top_q);
                            bot_q <= sat_inc(bot_q);
                        end else begin
                            bot_q <= '0;
                        end
                    end
                    TRK_BODY: begin
                        bot_q <= line_black ? sat_inc(bot_q) : '0;
                    end
                    default: begin
                        top_q <= '0;
                        bot_q <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/lbx_result_acc.sv
module lbx_result_acc
    import lbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_stb,
    input  logic        acc_wr,
    input  logic        fld_vld,
    input  fld_res_t    fld_res,
    output logic [15:0] reg_val
);

    logic [LBX_CNT_W-1:0] min_top_q, min_bot_q;
    logic [LBX_CNT_W-1:0] base_top, base_bot;
    logic                 blk_q;
    logic                 rd_go;

    always_comb begin
        rd_go    = acc_stb && !acc_wr;
        base_top = rd_go ? LBX_CNT_MAX : min_top_q;
        base_bot = rd_go ? LBX_CNT_MAX : min_bot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_top_q <= LBX_CNT_MAX;
            min_bot_q <= LBX_CNT_MAX;
            blk_q     <= 1'b0;
        end else begin
            if (fld_vld) begin
                min_top_q <= (fld_res.top < base_top) ? fld_res.top : base_top;
                min_bot_q <= (fld_res.bot < base_bot) ? fld_res.bot : base_bot;
                blk_q     <= fld_res.all_black;
            end else begin
                min_top_q <= base_top;
                min_bot_q <= base_bot;
            end
        end
    end

    always_comb begin
        reg_val = {blk_q, min_top_q, 1'b0, min_bot_q};
    end

endmodule

// File: rtl/lbx_detect.sv
module lbx_detect
    import lbx_pkg::*;
#(
    parameter int LUMA_W    = 8,
    parameter int BLACK_MAX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_vld,
    input  logic [LUMA_W-1:0] luma,
    input  logic              eol,
    input  logic              eof,
    input  logic              acc_stb,
    input  logic              acc_wr,
    output logic [15:0]       rd_data
);

    logic     line_vld;
    logic     line_black;
    logic     fld_end;
    logic     fld_vld;
    fld_res_t fld_res;

    lbx_line_class #(
        .LUMA_W   (LUMA_W),
        .BLACK_MAX(BLACK_MAX)
    ) u_class (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_vld   (act_vld),
        .luma      (luma),
        .eol       (eol),
        .eof       (eof),
        .line_vld  (line_vld),
        .line_black(line_black),
        .fld_end   (fld_end)
    );

    lbx_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_vld  (line_vld),
        .line_black(line_black),
        .fld_end   (fld_end),
        .fld_vld   (fld_vld),
        .fld_res   (fld_res)
    );

    lbx_result_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_stb (acc_stb),
        .acc_wr  (acc_wr),
        .fld_vld (fld_vld),
        .fld_res (fld_res),
        .reg_val (rd_data)
    );

endmodule

// File: rtl/lbx_detect_chk.sv
module lbx_detect_chk
    import lbx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_stb,
    input logic        acc_wr,
    input logic [15:0] rd_data,
    input logic        fld_vld,
    input fld_res_t    fld_res
);

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !acc_wr && !fld_vld) |=> (rd_data[14:8] == 7'h7F && rd_data[6:0] == 7'h7F));

    // R9
    wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && acc_wr && !fld_vld) |=> $stable(rd_data));

    // R5
    top_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_stb && !acc_wr) |=> (rd_data[14:8] <= $past(rd_data[14:8])));

    // R5
    bot_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_stb && !acc_wr) |=> (rd_data[6:0] <= $past(rd_data[6:0])));

    // R5
    land_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_vld |=> (rd_data[14:8] <= $past(fld_res.top)));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fld_vld |=> $stable(rd_data[15]));

    // R6
    allblk_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_vld && fld_res.all_black) |-> (fld_res.top == fld_res.bot));

endmodule

bind lbx_detect lbx_detect_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_stb(acc_stb),
    .acc_wr (acc_wr),
    .rd_data(rd_data),
    .fld_vld(fld_vld),
    .fld_res(fld_res)
);

// File: tb/tb_lbx_detect.sv
`timescale 1ns/1ps
module tb_lbx_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_vld = 1'b0;
    logic [7:0] luma = 8'd0;
    logic       eol = 1'b0;
    logic       eof = 1'b0;
    logic       acc_stb = 1'b0;
    logic       acc_wr = 1'b0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lbx_detect dut (
        .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .luma(luma),
        .eol(eol), .eof(eof), .acc_stb(acc_stb), .acc_wr(acc_wr),
        .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // behavioural reference model
    typedef struct {int due; int t; int b; bit a;} pend_t;
    pend_t pq[$];
    pend_t pe;
    bit    lines[$];
    bit    cur_br;
    int    cyc;
    int    mt, mb;
    bit    mf;
    int    rt, rb;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; mt = 127; mb = 127; mf = 0; cur_br = 0;
            lines.delete(); pq.delete();
        end else begin
            cyc++;
            if (acc_stb && !acc_wr) begin mt = 127; mb = 127; end
            if (pq.size() > 0 && pq[0].due == cyc) begin
                pe = pq.pop_front();
                if (pe.t < mt) mt = pe.t;
                if (pe.b < mb) mb = pe.b;
                mf = pe.a;
            end
            if (act_vld && luma > 8'd32) cur_br = 1;
            if (eol) begin lines.push_back(!cur_br); cur_br = 0; end
            if (eof) begin
                if (lines.size() > 0) begin
                    rt = 0;
                    while (rt < lines.size() && lines[rt]) rt++;
                    rb = 0;
                    while (rb < lines.size() && lines[lines.size()-1-rb]) rb++;
                    pe.due = cyc + 2;
                    pe.a = (rt == lines.size());
                    pe.t = (rt > 127) ? 127 : rt;
                    pe.b = (rb > 127) ? 127 : rb;
                    pq.push_back(pe);
                end
                lines.delete();
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done)
            chk("R10 per-cycle model", rd_data, {mf, 7'(mt), 1'b0, 7'(mb)});
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_line(input int lv, input int peak, input bit peak_eol);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); act_vld = 1; luma = 8'(lv);
        end
        if (!peak_eol) begin
            @(negedge clk); act_vld = 1; luma = 8'(peak);
            @(negedge clk); act_vld = 0; luma = 8'd255; eol = 1;
        end else begin
            @(negedge clk); act_vld = 1; luma = 8'(peak); eol = 1;
        end
        @(negedge clk); act_vld = 0; luma = 8'd250; eol = 0;
    endtask

    task automatic end_field(input bit rd_land);
        idle(2);
        eof = 1;
        @(negedge clk); eof = 0;
        if (rd_land) begin
            @(negedge clk); acc_stb = 1; acc_wr = 0;
            @(negedge clk); acc_stb = 0;
        end
        idle(3);
    endtask

    task automatic run_field(input int nt, input int nb, input int nbo, input bit rd_land);
        for (int i = 0; i < nt; i++) send_line(10, 10, 0);
        for (int i = 0; i < nb; i++) send_line(10, 200, 0);
        for (int i = 0; i < nbo; i++) send_line(10, 10, 0);
        end_field(rd_land);
    endtask

    task automatic do_read(input string tag, input logic [15:0] exp_now, input logic [15:0] exp_after);
        @(negedge clk); acc_stb = 1; acc_wr = 0;
        chk(tag, rd_data, exp_now);
        @(negedge clk); acc_stb = 0;
        chk(tag, rd_data, exp_after);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 reset value in reset", rd_data, 16'h7F7F);
        rst_n = 1;
        idle(2);
        chk("R1 reset value", rd_data, 16'h7F7F);

        // R3 R4 R10: top 3, bottom 4
        run_field(3, 2, 4, 0);
        chk("R3 R4 R10 first field", rd_data, 16'h0304);

        // R5 minimum merge
        run_field(1, 5, 2, 0);
        chk("R5 min merge", rd_data, 16'h0102);

        // R8 read clears
        do_read("R8 read", 16'h0102, 16'h7F7F);

        // R2 threshold 32 black, 33 bright
        send_line(32, 32, 0);
        send_line(32, 33, 0);
        send_line(20, 32, 0);
        end_field(0);
        chk("R2 threshold", rd_data, 16'h0101);
        do_read("R8 read again", 16'h0101, 16'h7F7F);

        // R2 bright sample with eol
        send_line(10, 10, 0);
        send_line(10, 200, 1);
        send_line(10, 10, 0);
        send_line(10, 10, 0);
        end_field(0);
        chk("R2 sample on eol", rd_data, 16'h0102);
        do_read("R8 read third", 16'h0102, 16'h7F7F);

        // R6 all-black field
        run_field(5, 0, 0, 0);
        chk("R6 black picture", rd_data, 16'h8505);

        // R9 write ignored
        @(negedge clk); acc_stb = 1; acc_wr = 1;
        @(negedge clk); acc_stb = 0; acc_wr = 0;
        idle(1);
        chk("R9 write ignored", rd_data, 16'h8505);

        // R6 flag survives a read
        do_read("R6 flag after read", 16'h8505, 16'hFF7F);

        // R7 empty field
        end_field(0);
        chk("R7 empty field", rd_data, 16'hFF7F);

        // R3 R4 saturation on 130 black lines
        run_field(130, 0, 0, 0);
        chk("R3 R4 saturation", rd_data, 16'hFF7F);

        // R6 flag clears on a normal field
        run_field(2, 1, 3, 0);
        chk("R6 flag cleared", rd_data, 16'h0203);

        // R8 read coinciding with landing result
        run_field(4, 1, 5, 1);
        chk("R8 read at landing", rd_data, 16'h0405);

        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule